// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block collects the interrupt conditions of a UART, ranks them, and produces the eight-bit interrupt identification value and the interrupt request line. It watches five sources: receive line errors, receive data available, receive character time-out, transmit holding register empty, and modem status changes. Each source can be masked by its own enable. Only the most urgent enabled source is reported.

The receive character time-out counter is part of the block. It counts 16x baud ticks while the receive FIFO holds data. The limit is four character times, computed from the programmed word length, parity and stop-bit setting. The host register decoder supplies one-cycle read and write strobes. The receive path supplies the FIFO fill count, the stop-bit-centre strobe and the error and change events.

Top module: `uart_irq_ident`

## Requirements
- R1: The low nibble of `isr` reports the enabled pending source of highest rank. The ranking runs from highest to lowest: line status 4'b0110, receive data 4'b0100, receive time-out 4'b1100, transmit empty 4'b0010, modem status 4'b0000. Receive data and time-out share one rank; when both are pending, data is reported.
- R2: `isr[0]` is 1 exactly when no enabled source is pending, and the low nibble is then 4'b0001.
- R3: `isr[7:6]` read 2'b11 when `fifo_en` is 1 and 2'b00 otherwise. `isr[5]` reads 1 only when both `fifo_en` and `fifo_deep` are 1. `isr[4]` is 0.
- R4: In FIFO mode the receive data source is pending while `rx_count` is nonzero and at least `rx_trigger`, and not pending below that level. With FIFOs off it is pending whenever `rx_count` is nonzero.
- R5: In FIFO mode the time-out becomes pending after 4 character times counted in `baud_tick` pulses while `rx_count` is nonzero. It is never pending while `rx_count` is zero or FIFOs are off. One character time in ticks is 16 x (1 + (5 + `word_len`) + `parity_on`) plus the stop time. The stop time is 16 for one stop bit. With `stop_two` set it is 24 when `word_len` is 0 and 32 otherwise.
- R6: A `stop_centre` or `rhr_read` strobe clears a pending time-out and restarts the count from zero.
- R7: Transmit empty becomes pending on `tx_empty_event`. It clears on `thr_write`, or on an `isr_read` while `isr` currently shows 4'b0010. An `isr_read` while another code is shown leaves it pending. A set and a clear in the same cycle leave it pending.
- R8: Line status clears only on `line_read`, and modem status clears only on `modem_read`. An `isr_read` does not clear either of them.
- R9: A source whose enable is 0 is never reported. `irq` is 1 exactly when some enabled source is pending.
- R10: `isr` and `irq` are registered and show the result of the inputs sampled at the previous clock edge. The synchronous reset sets `isr` to 8'h01 and `irq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFOs enabled |
| fifo_deep | input | 1 | 64-entry FIFO mode selected |
| en_line | input | 1 | Enable for line status source |
| en_rx | input | 1 | Enable for receive data and time-out sources |
| en_tx | input | 1 | Enable for transmit empty source |
| en_modem | input | 1 | Enable for modem status source |
| rx_count | input | CW | Receive FIFO fill count |
| rx_trigger | input | CW | Receive trigger level |
| word_len | input | 2 | Data bits minus five |
| parity_on | input | 1 | Parity bit present |
| stop_two | input | 1 | Long stop setting |
| baud_tick | input | 1 | 16x baud tick pulse |
| stop_centre | input | 1 | Strobe at centre of a received stop bit |
| rhr_read | input | 1 | Receive holding register read strobe |
| line_event | input | 1 | Receive error detected pulse |
| line_read | input | 1 | Line status register read strobe |
| modem_event | input | 1 | Modem input change pulse |
| modem_read | input | 1 | Modem status register read strobe |
| tx_empty_event | input | 1 | Transmit holding/FIFO became empty pulse |
| thr_write | input | 1 | Transmit holding register write strobe |
| isr_read | input | 1 | Interrupt status register read strobe |
| isr | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request |

## Verification
The tests raise several sources together and remove them one at a time, so each reported code shows that the ranking is right. Exact tick counts, one below the limit and at the limit, are tried for two different character formats; these separate a correct character-time formula from an off-by-one. Status reads are issued while some other source is shown, which tells a read that clears only the reported source apart from one that clears everything. Clearing each enable and switching FIFO mode off test the masking and the upper identification bits.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IRQ_MODEM     = 4'b0000,
    IRQ_NONE      = 4'b0001,
    IRQ_TXEMPTY   = 4'b0010,
    IRQ_RXDATA    = 4'b0100,
    IRQ_LINE      = 4'b0110,
    IRQ_RXTIMEOUT = 4'b1100
  } irq_code_e;

  typedef struct packed {
    logic line;
    logic rxdata;
    logic rxtimeout;
    logic txempty;
    logic modem;
  } irq_src_t;

  localparam int FLAG_LINE  = 0;
  localparam int FLAG_MODEM = 1;
  localparam int FLAG_TX    = 2;
  localparam int NUM_FLAGS  = 3;
endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int CW            = 7,
  parameter int TICKS_PER_BIT = 16,
  parameter int CHAR_WINDOWS  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [CW-1:0] rx_count,
  input  logic [1:0]    word_len,
  input  logic          parity_on,
  input  logic          stop_two,
  input  logic          baud_tick,
  input  logic          stop_centre,
  input  logic          rhr_read,
  output logic          to_nxt
);
  localparam int MAX_BITS = 12;
  localparam int LIM_W    = $clog2(TICKS_PER_BIT * MAX_BITS * CHAR_WINDOWS + 1);

  logic [LIM_W-1:0] cnt_q, cnt_d, body_t, stop_t, char_t, limit;
  logic             pend_q, pend_d, restart;

  always_comb begin
    body_t = LIM_W'(TICKS_PER_BIT) *
             (LIM_W'(6) + LIM_W'(word_len) + LIM_W'(parity_on));
    if (!stop_two)           stop_t = LIM_W'(TICKS_PER_BIT);
    else if (word_len == 2'd0) stop_t = LIM_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
    else                     stop_t = LIM_W'(2 * TICKS_PER_BIT);
    char_t = body_t + stop_t;
    limit  = char_t * LIM_W'(CHAR_WINDOWS);
  end

  assign restart = !fifo_en || (rx_count == '0) || stop_centre || rhr_read;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (restart) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (baud_tick && !pend_q) begin
      if (cnt_q == limit - LIM_W'(1)) begin
        cnt_d  = '0;
        pend_d = 1'b1;
      end else begin
        cnt_d = cnt_q + LIM_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign to_nxt = pend_d;
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_nxt
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign flag_nxt[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_nxt[i];
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_src_t   active,
  output logic [3:0] code,
  output logic       any
);
  always_comb begin
    any = 1'b1;
    if (active.line)           code = IRQ_LINE;
    else if (active.rxdata)    code = IRQ_RXDATA;
    else if (active.rxtimeout) code = IRQ_RXTIMEOUT;
    else if (active.txempty)   code = IRQ_TXEMPTY;
    else if (active.modem)     code = IRQ_MODEM;
    else begin
      code = IRQ_NONE;
      any  = 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH    = 64,
  parameter int TICKS_PER_BIT = 16,
  parameter int CHAR_WINDOWS  = 4,
  parameter int CW            = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          fifo_deep,
  input  logic          en_line,
  input  logic          en_rx,
  input  logic          en_tx,
  input  logic          en_modem,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_trigger,
  input  logic [1:0]    word_len,
  input  logic          parity_on,
  input  logic          stop_two,
  input  logic          baud_tick,
  input  logic          stop_centre,
  input  logic          rhr_read,
  input  logic          line_event,
  input  logic          line_read,
  input  logic          modem_event,
  input  logic          modem_read,
  input  logic          tx_empty_event,
  input  logic          thr_write,
  input  logic          isr_read,
  output logic [7:0]    isr,
  output logic          irq
);
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_nxt;
  logic                 to_nxt, rda_nxt, thre_shown;
  irq_src_t             active;
  logic [3:0]           code;
  logic                 any;

  assign thre_shown = (isr[3:0] == IRQ_TXEMPTY);

  always_comb begin
    flag_set = '0;
    flag_clr = '0;
    flag_set[FLAG_LINE]  = line_event;
    flag_clr[FLAG_LINE]  = line_read;
    flag_set[FLAG_MODEM] = modem_event;
    flag_clr[FLAG_MODEM] = modem_read;
    flag_set[FLAG_TX]    = tx_empty_event;
    flag_clr[FLAG_TX]    = thr_write | (isr_read & thre_shown);
  end

  uart_irq_flags #(.N(NUM_FLAGS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_i    (flag_set),
    .clr_i    (flag_clr),
    .flag_nxt (flag_nxt)
  );

  uart_irq_timeout #(
    .CW            (CW),
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .CHAR_WINDOWS  (CHAR_WINDOWS)
  ) u_timeout (
    .clk         (clk),
    .rst         (rst),
    .fifo_en     (fifo_en),
    .rx_count    (rx_count),
    .word_len    (word_len),
    .parity_on   (parity_on),
    .stop_two    (stop_two),
    .baud_tick   (baud_tick),
    .stop_centre (stop_centre),
    .rhr_read    (rhr_read),
    .to_nxt      (to_nxt)
  );

  assign rda_nxt = fifo_en ? ((rx_count != '0) && (rx_count >= rx_trigger))
                           : (rx_count != '0);

  always_comb begin
    active.line      = en_line  & flag_nxt[FLAG_LINE];
    active.rxdata    = en_rx    & rda_nxt;
    active.rxtimeout = en_rx    & to_nxt;
    active.txempty   = en_tx    & flag_nxt[FLAG_TX];
    active.modem     = en_modem & flag_nxt[FLAG_MODEM];
  end

  uart_irq_prio u_prio (
    .active (active),
    .code   (code),
    .any    (any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      isr <= {4'b0000, IRQ_NONE};
      irq <= 1'b0;
    end else begin
      isr <= {fifo_en, fifo_en, fifo_en & fifo_deep, 1'b0, code};
      irq <= any;
    end
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          fifo_deep,
  input logic          en_line,
  input logic          en_rx,
  input logic          en_tx,
  input logic          en_modem,
  input logic [CW-1:0] rx_count,
  input logic          line_event,
  input logic          line_read,
  input logic          tx_empty_event,
  input logic          thr_write,
  input logic [7:0]    isr,
  input logic          irq
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (isr[3:0] == 4'b0001) && !irq);  // R10

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    isr[3:0] inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000});  // R1

  AST_IDLE_BIT: assert property (@(posedge clk) disable iff (rst)
    isr[0] |-> (isr[3:1] == 3'b000) && !irq);  // R2

  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (isr[7:6] == {2{$past(fifo_en)}}) && (isr[5] == $past(fifo_en & fifo_deep)));  // R3

  AST_NO_TIMEOUT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |=> (isr[3:0] != 4'b1100));  // R5

  AST_THRE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (thr_write && !tx_empty_event) |=> (isr[3:0] != 4'b0010));  // R7

  AST_LINE_READ: assert property (@(posedge clk) disable iff (rst)
    (line_read && !line_event) |=> (isr[3:0] != 4'b0110));  // R8

  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
    !(en_line || en_rx || en_tx || en_modem) |=> !irq);  // R9
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CW(CW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fifo_en        (fifo_en),
  .fifo_deep      (fifo_deep),
  .en_line        (en_line),
  .en_rx          (en_rx),
  .en_tx          (en_tx),
  .en_modem       (en_modem),
  .rx_count       (rx_count),
  .line_event     (line_event),
  .line_read      (line_read),
  .tx_empty_event (tx_empty_event),
  .thr_write      (thr_write),
  .isr            (isr),
  .irq            (irq)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 0, fifo_deep = 0, en_line = 0, en_rx = 0, en_tx = 0, en_modem = 0;
  logic [CW-1:0] rx_count = '0, rx_trigger = '0;
  logic [1:0] word_len = 2'd0;
  logic parity_on = 0, stop_two = 0, baud_tick = 0, stop_centre = 0, rhr_read = 0;
  logic line_event = 0, line_read = 0, modem_event = 0, modem_read = 0;
  logic tx_empty_event = 0, thr_write = 0, isr_read = 0;
  logic [7:0] isr;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ident u_dut (.*);

  // behavioural reference
  int m_line, m_modem, m_thre, m_cnt, m_to, m_lim, m_code;
  bit m_rda;
  logic [7:0] exp_isr = 8'h01;
  bit exp_irq = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_line = 0; m_modem = 0; m_thre = 0; m_cnt = 0; m_to = 0;
      exp_isr = 8'h01; exp_irq = 0;
    end else begin
      bit shown_thre;
      shown_thre = (exp_isr[3:0] == 4'b0010);
      if (line_read) m_line = 0;
      if (line_event) m_line = 1;
      if (modem_read) m_modem = 0;
      if (modem_event) m_modem = 1;
      if (thr_write || (isr_read && shown_thre)) m_thre = 0;
      if (tx_empty_event) m_thre = 1;
      m_lim = 4 * (16 * (1 + 5 + int'(word_len) + int'(parity_on)) +
                   (stop_two ? ((word_len == 0) ? 24 : 32) : 16));
      if (!fifo_en || rx_count == 0 || stop_centre || rhr_read) begin
        m_cnt = 0; m_to = 0;
      end else if (baud_tick && m_to == 0) begin
        m_cnt++;
        if (m_cnt == m_lim) begin m_to = 1; m_cnt = 0; end
      end
      m_rda = fifo_en ? (rx_count != 0 && rx_count >= rx_trigger) : (rx_count != 0);
      if (en_line && m_line != 0)        m_code = 6;
      else if (en_rx && m_rda)           m_code = 4;
      else if (en_rx && m_to != 0)       m_code = 12;
      else if (en_tx && m_thre != 0)     m_code = 2;
      else if (en_modem && m_modem != 0) m_code = 0;
      else                               m_code = 1;
      exp_isr = {fifo_en, fifo_en, fifo_en & fifo_deep, 1'b0, 4'(m_code)};
      exp_irq = (m_code != 1);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (isr !== exp_isr || irq !== exp_irq) begin
        bad++;
        $display("FAIL R10 cycle compare: isr=%h irq=%b expected isr=%h irq=%b",
                 isr, irq, exp_isr, exp_irq);
      end
    end
  end

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    chk("R10 reset value", {irq, isr}, {1'b0, 8'h01});

    // FIFO 64 mode, all enables
    fifo_en = 1; fifo_deep = 1; en_line = 1; en_rx = 1; en_tx = 1; en_modem = 1;
    rx_trigger = 7'd16; word_len = 2'd3;
    cyc(1);
    chk("R3 R2 idle fifo bits", {irq, isr}, {1'b0, 8'hE1});

    // several sources at once, peel off
    modem_event = 1; tx_empty_event = 1; line_event = 1; rx_count = 7'd16;
    cyc(1);
    modem_event = 0; tx_empty_event = 0; line_event = 0;
    chk("R1 line highest", {irq, isr}, {1'b1, 8'hE6});
    isr_read = 1; cyc(1); isr_read = 0;
    chk("R8 isr read keeps line", {1'b0, isr}, {1'b0, 8'hE6});
    line_read = 1; cyc(1); line_read = 0;
    chk("R1 rx data next", {1'b0, isr}, {1'b0, 8'hE4});
    rx_count = 7'd15; cyc(1);
    chk("R4 below trigger", {1'b0, isr}, {1'b0, 8'hE2});
    rx_count = 7'd0;
    isr_read = 1; cyc(1); isr_read = 0;
    chk("R7 read clears shown tx empty", {1'b0, isr}, {1'b0, 8'hE0});
    isr_read = 1; cyc(1); isr_read = 0;
    chk("R8 isr read keeps modem", {1'b0, isr}, {1'b0, 8'hE0});
    modem_read = 1; cyc(1); modem_read = 0;
    chk("R8 modem read clears", {irq, isr}, {1'b0, 8'hE1});

    // tx empty not cleared by a read showing another code; write clears
    tx_empty_event = 1; line_event = 1; cyc(1); tx_empty_event = 0; line_event = 0;
    isr_read = 1; cyc(1); isr_read = 0;
    line_read = 1; cyc(1); line_read = 0;
    chk("R7 tx empty survives other read", {1'b0, isr}, {1'b0, 8'hE2});
    thr_write = 1; tx_empty_event = 1; cyc(1); thr_write = 0; tx_empty_event = 0;
    chk("R7 set beats clear", {1'b0, isr}, {1'b0, 8'hE2});
    thr_write = 1; cyc(1); thr_write = 0;
    chk("R7 write clears", {1'b0, isr}, {1'b0, 8'hE1});

    // time-out, 8N1: 4*160 = 640 ticks
    rx_count = 7'd3; baud_tick = 1;
    cyc(639);
    chk("R5 one tick short", {1'b0, isr}, {1'b0, 8'hE1});
    cyc(1);
    chk("R5 timeout at limit", {irq, isr}, {1'b1, 8'hEC});
    rhr_read = 1; cyc(1); rhr_read = 0;
    chk("R6 read clears timeout", {1'b0, isr}, {1'b0, 8'hE1});
    cyc(600);
    stop_centre = 1; cyc(1); stop_centre = 0;
    cyc(639);
    chk("R6 stop centre restarts", {1'b0, isr}, {1'b0, 8'hE1});
    cyc(1);
    chk("R6 timeout after restart", {1'b0, isr}, {1'b0, 8'hEC});

    // 5 bits, parity, long stop: 4*(112+24) = 544
    word_len = 2'd0; parity_on = 1; stop_two = 1; rhr_read = 1;
    cyc(1); rhr_read = 0;
    cyc(543);
    chk("R5 5-bit format short", {1'b0, isr}, {1'b0, 8'hE1});
    cyc(1);
    chk("R5 5-bit format limit", {1'b0, isr}, {1'b0, 8'hEC});

    // empty FIFO never times out
    rx_count = 7'd0; cyc(700);
    chk("R5 empty no timeout", {1'b0, isr}, {1'b0, 8'hE1});
    baud_tick = 0;

    // masking
    en_line = 0; en_rx = 0; en_tx = 0; en_modem = 0;
    line_event = 1; modem_event = 1; tx_empty_event = 1; rx_count = 7'd20;
    cyc(1); line_event = 0; modem_event = 0; tx_empty_event = 0;
    chk("R9 all masked", {irq, isr}, {1'b0, 8'hE1});
    en_modem = 1; cyc(1);
    chk("R9 only modem enabled", {irq, isr}, {1'b1, 8'hE0});
    en_modem = 0; line_read = 1; modem_read = 1; thr_write = 1;
    cyc(1); line_read = 0; modem_read = 0; thr_write = 0;

    // FIFOs off and shallow mode
    en_rx = 1; fifo_deep = 0; cyc(1);
    chk("R3 shallow bit5", {1'b0, isr}, {1'b0, 8'hC4});
    fifo_en = 0; rx_count = 7'd1; rx_trigger = 7'd30; cyc(1);
    chk("R4 fifo off single char", {irq, isr}, {1'b1, 8'h04});
    rx_count = 7'd0; cyc(1);
    chk("R2 fifo off idle", {irq, isr}, {1'b0, 8'h01});

    rst = 1; cyc(1); rst = 0;
    chk("R10 reset again", {irq, isr}, {1'b0, 8'h01});
    cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule